// File: doc/BRIEF.md
# Quarter-Wave Twiddle Factor Generator

This block supplies the complex rotation constant W = cos(2πk/64) − j·sin(2πk/64) for any index k in 0..63. A 64-point pipelined FFT uses these constants between its stage pairs. The rotation is computed on the fly from a 17-entry constant table. That table holds only the non-negative sine magnitudes of the first quarter period.

The index is split into a quadrant number and an offset within that quadrant. Cosine is read through the complementary table address, and sine through the direct one. In odd quadrants the two addresses swap roles. The sign of each part is then set from the quadrant alone.

Both parts leave the block as registered 10-bit two's-complement values scaled by 512. A magnitude of 1.0 is clipped to 511. The output valid flag follows the input valid flag one clock later.

Top module: `twiddle_gen`

## Requirements
- R1: While rst_n is low, and at the first clock edge after it rises, out_valid is 0 and out_re and out_im are 0.
- R2: out_valid equals the in_valid sampled at the previous rising clock edge. The rotation for an accepted index appears one cycle after acceptance.
- R3: out_re is round(512·cos(2πk/64)) as a signed 10-bit value, within one LSB, with k = in_idx.
- R4: out_im is round(−512·sin(2πk/64)) as a signed 10-bit value, within one LSB.
- R5: The magnitude of out_re and out_im never exceeds 511, and neither output ever shows −512.
- R6: The axis points are exact. k=0 gives (511, 0), k=16 gives (0, −511), k=32 gives (−511, 0) and k=48 gives (0, 511).
- R7: The quadrant is in_idx[5:4]. out_re is never negative in quadrants 0 and 3. out_im is never negative in quadrants 2 and 3.
- R8: When in_valid is low at an edge, out_re and out_im keep their values, whatever in_idx holds.
- R9: The diagonal points k=8, 24, 40 and 56 give magnitude 362 on both parts, with the signs set by the quadrant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_idx is valid this cycle |
| in_idx | input | 6 | Twiddle index k |
| out_valid | output | 1 | Registered outputs hold a new rotation |
| out_re | output | 10 | Signed real part, cos scaled by 512 |
| out_im | output | 10 | Signed imaginary part, −sin scaled by 512 |

## Verification
The only state in this block is the output register. A wrong table entry or a swapped fold address therefore shows at the ports in the very cycle after the offending index is accepted, as a value off by more than one LSB. A sign error shows at the same point as a mirrored value, and is most visible at the diagonal and axis indices. A slip in the hold-enable logic shows as a changed output on the first edge with in_valid low. Sweeping all 64 indices once therefore exposes every table entry under both the direct and the complementary address.

// File: rtl/twiddle_gen.sv
module twiddle_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [5:0] in_idx,
  output logic       out_valid,
  output logic [9:0] out_re,
  output logic [9:0] out_im
);
  logic [1:0] quad;
  logic [3:0] ofs;
  logic [4:0] fold_lo, fold_hi, cos_addr, sin_addr;
  logic [8:0] cos_mag, sin_mag;
  logic       re_neg, im_neg;

  function automatic logic [8:0] sine_rom(input logic [4:0] a);
    case (a)
      5'd0:  sine_rom = 9'd0;
      5'd1:  sine_rom = 9'd50;
      5'd2:  sine_rom = 9'd100;
      5'd3:  sine_rom = 9'd149;
      5'd4:  sine_rom = 9'd196;
      5'd5:  sine_rom = 9'd241;
      5'd6:  sine_rom = 9'd284;
      5'd7:  sine_rom = 9'd325;
      5'd8:  sine_rom = 9'd362;
      5'd9:  sine_rom = 9'd396;
      5'd10: sine_rom = 9'd426;
      5'd11: sine_rom = 9'd452;
      5'd12: sine_rom = 9'd473;
      5'd13: sine_rom = 9'd490;
      5'd14: sine_rom = 9'd502;
      5'd15: sine_rom = 9'd510;
      default: sine_rom = 9'd511;
    endcase
  endfunction

  assign quad     = in_idx[5:4];
  assign ofs      = in_idx[3:0];
  assign fold_lo  = {1'b0, ofs};
  assign fold_hi  = 5'd16 - {1'b0, ofs};
  assign cos_addr = quad[0] ? fold_lo : fold_hi;
  assign sin_addr = quad[0] ? fold_hi : fold_lo;
  assign cos_mag  = sine_rom(cos_addr);
  assign sin_mag  = sine_rom(sin_addr);
  assign re_neg   = quad[0] ^ quad[1];
  assign im_neg   = ~quad[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= re_neg ? (10'd0 - {1'b0, cos_mag}) : {1'b0, cos_mag};
        out_im <= im_neg ? (10'd0 - {1'b0, sin_mag}) : {1'b0, sin_mag};
      end
    end
  end
endmodule

module twiddle_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [5:0] in_idx,
  input logic       out_valid,
  input logic [9:0] out_re,
  input logic [9:0] out_im
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_NO_MIN_RE: assert property (@(posedge clk) disable iff (!rst_n) out_re != 10'h200); // R5
  AST_NO_MIN_IM: assert property (@(posedge clk) disable iff (!rst_n) out_im != 10'h200); // R5
  AST_RE_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (in_idx[5:4] == 2'd0 || in_idx[5:4] == 2'd3)) |=> !out_re[9]); // R7
  AST_IM_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_idx[5]) |=> !out_im[9]); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!in_valid && $past(rst_n)) |=> ($stable(out_re) && $stable(out_im))); // R8
endmodule

bind twiddle_gen twiddle_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/twiddle_gen_bench.sv
`timescale 1ns/1ps
module twiddle_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [5:0] in_idx = '0;
  logic       out_valid;
  logic [9:0] out_re, out_im;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twiddle_gen u_twiddle_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  // {index, expected re, expected im}: axis (R6) and diagonal (R9) points
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{0, 511, 0}, '{8, 362, -362}, '{16, 0, -511}, '{24, -362, -362},
    '{32, -511, 0}, '{40, -362, 362}, '{48, 0, 511}, '{56, 362, 362}
  };

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    checks++;
    if (d > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int k);
    @(negedge clk);
    in_valid = 1'b1;
    in_idx   = k[5:0];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int ref_val(input real x);
    int v;
    v = (x < 0.0) ? $rtoi(x - 0.5) : $rtoi(x + 0.5);
    if (v > 511) v = 511;
    if (v < -511) v = -511;
    return v;
  endfunction

  initial begin
    int sre, sim;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0, 0);
    check("R1 re in reset", int'($signed(out_re)), 0, 0);
    check("R1 im in reset", int'($signed(out_im)), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][0]);
      check("R2 valid latency", int'(out_valid), 1, 0);
      check(VEC[i][0] % 16 == 0 ? "R6 re" : "R9 re", int'($signed(out_re)), VEC[i][1], 0);
      check(VEC[i][0] % 16 == 0 ? "R6 im" : "R9 im", int'($signed(out_im)), VEC[i][2], 0);
      @(negedge clk);
      check("R2 valid drop", int'(out_valid), 0, 0);
    end

    for (int k = 0; k < 64; k++) begin
      real ang;
      ang = 2.0 * 3.14159265358979 * k / 64.0;
      apply(k);
      check("R3 re sweep", int'($signed(out_re)), ref_val(512.0 * $cos(ang)), 1);
      check("R4 im sweep", int'($signed(out_im)), ref_val(-512.0 * $sin(ang)), 1);
      checks++;
      if (out_re == 10'h200 || out_im == 10'h200) begin
        failures++;
        $display("FAIL R5 k=%0d actual=%0d/%0d expected=>-512", k,
                 $signed(out_re), $signed(out_im));
      end
    end

    apply(5);
    sre = int'($signed(out_re));
    sim = int'($signed(out_im));
    in_idx = 6'd40;
    repeat (4) @(negedge clk);
    check("R8 re hold", int'($signed(out_re)), sre, 0);
    check("R8 im hold", int'($signed(out_im)), sim, 0);
    check("R7 re sign q0", int'(out_re[9]), 0, 0);

    apply(33);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run re", int'($signed(out_re)), 0, 0);
    check("R1 mid-run valid", int'(out_valid), 0, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule